// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block steers a single data lane of a camera-serial transmitter through one high-speed burst at a time. While idle it holds both low-power line levels high. When a burst is requested, it holds the stop level for a fixed dwell and then walks the low-power entry ladder. It enters high-speed mode, sends a run of zero bytes, and can insert a calibration run of the deskew pattern. A single sync byte follows. After that, payload bytes pass through from an upstream byte stream until the upstream marks the final byte. The lane then drives a trail pattern and drops back to the stop level.

The outputs are the two low-power line levels, a high-speed enable for an external serializer, and the byte that the serializer sends in the current cycle. The stop-level dwell is a build-time parameter. Every other dwell is a run-time count input, measured in clock cycles. The receiver needs the deskew run when the lane rate is above 1.5 Gbps. The run is switched by `deskew_en`, so it can be turned off at lower rates or while debugging.

The payload input is valid/ready. `pl_ready` is high only in the payload phase. A byte is taken in every cycle where `pl_valid` and `pl_ready` are both high. The upstream should keep `pl_valid` high for the whole phase. If `pl_valid` drops, the lane has no idle code, so it repeats the last byte it sent. The burst ends on the accepted byte that has `pl_last` set.

Top module: `lane_burst_seq`

## Requirements
- R1: After reset, and whenever no burst is running, `lp_pos`=1, `lp_neg`=1, `hs_en`=0, `busy`=0 and `pl_ready`=0.
- R2: A `burst_req` sampled high while idle starts a burst in the next cycle. `busy` goes high and stays high until idle is reached again. Both lines stay high for `LP11_CYC` cycles.
- R3: Next, the lines go to `lp_pos`=0, `lp_neg`=1 for `cnt_lp01` cycles. After that, both lines go low for `cnt_lp00` cycles.
- R4: High-speed mode (`hs_en`=1, both lines low) begins with `cnt_hszero` cycles of byte 0x00.
- R5: If `deskew_en` was high in the cycle the request was taken, `cnt_deskew` cycles of byte 0xBC follow the zeros. Otherwise this run is skipped. Changes to `deskew_en` during a burst have no effect.
- R6: Exactly one cycle of sync byte 0xB8 comes before the first payload cycle.
- R7: In the payload phase `pl_ready`=1. When `pl_valid`=1, `hs_byte` equals `pl_data` in that same cycle. When `pl_valid`=0, `hs_byte` repeats the previous byte sent (0xB8 if no payload byte has been taken yet).
- R8: After an accepted byte that has `pl_last`=1, the lane sends `cnt_trail` trail cycles with `hs_en`=1. Each trail byte has every bit equal to the inverse of bit 7 of the last accepted byte. Bit 7 is the final bit serialized, because bytes are sent LSB first.
- R9: In the cycle after the last trail cycle, the lane is idle (R1).
- R10: A `burst_req` while `busy`=1 is ignored. It neither restarts nor extends the current burst, and it does not start a second one.
- R11: A count input of zero gives a dwell of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_req | input | 1 | Start a burst (sampled while idle) |
| deskew_en | input | 1 | Insert a deskew run (sampled with the request) |
| cnt_lp01 | input | CW | Cycles in the LP-01 state |
| cnt_lp00 | input | CW | Cycles in the LP-00 state |
| cnt_hszero | input | CW | Cycles of zero bytes |
| cnt_deskew | input | CW | Cycles of deskew pattern |
| cnt_trail | input | CW | Cycles of trail pattern |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Marks the final payload byte |
| pl_ready | output | 1 | Payload byte accepted when high together with valid |
| lp_pos | output | 1 | Low-power level, positive line |
| lp_neg | output | 1 | Low-power level, negative line |
| hs_en | output | 1 | Serializer enable |
| hs_byte | output | 8 | Byte to serialize this cycle |
| busy | output | 1 | Burst in progress |

## Verification
Two situations are hard to reach from the ports. The first is a payload stall, which has to land inside the one open payload window, and it must be checked that the lane repeats the previous byte rather than any other value. The second is a request that arrives while a burst is running. The bench paces the stream cycle by cycle from the observed `pl_ready`, inserts gaps both before the first byte and between bytes, and holds `burst_req` high through the whole zero run of a burst. It also flips `deskew_en` just after a request, which shows that the setting is latched with the request.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_BYTE   = 8'hB8;
  localparam logic [BYTE_W-1:0] DESKEW_BYTE = 8'hBC;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STOP, ST_LP01, ST_LP00, ST_ZERO,
    ST_DESKEW, ST_SYNC, ST_PAYLOAD, ST_TRAIL
  } lane_st_t;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem_q <= '0;
    else if (load)
      rem_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (rem_q != '0)
      rem_q <= rem_q - 1'b1;
  end

  assign done = (rem_q == '0);

  // R11
  zero_count_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val <= 1) |=> done);
endmodule

// File: rtl/hs_byte_sel.sv
module hs_byte_sel
  import lane_seq_pkg::*;
(
  input  lane_st_t          st,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [BYTE_W-1:0] prev_byte,
  output logic [BYTE_W-1:0] out_byte
);
  always_comb begin
    unique case (st)
      ST_DESKEW:  out_byte = DESKEW_BYTE;
      ST_SYNC:    out_byte = SYNC_BYTE;
      ST_PAYLOAD: out_byte = in_valid ? in_data : prev_byte;
      ST_TRAIL:   out_byte = {BYTE_W{~prev_byte[BYTE_W-1]}};
      default:    out_byte = '0;
    endcase
  end
endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
  import lane_seq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int LP11_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_req,
  input  logic              deskew_en,
  input  logic [CW-1:0]     cnt_lp01,
  input  logic [CW-1:0]     cnt_lp00,
  input  logic [CW-1:0]     cnt_hszero,
  input  logic [CW-1:0]     cnt_deskew,
  input  logic [CW-1:0]     cnt_trail,
  input  logic              pl_valid,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              pl_last,
  output logic              pl_ready,
  output logic              lp_pos,
  output logic              lp_neg,
  output logic              hs_en,
  output logic [BYTE_W-1:0] hs_byte,
  output logic              busy
);
  localparam logic [CW-1:0] STOP_DWELL = CW'(LP11_CYC);

  lane_st_t          st_q, st_d;
  logic              tmr_ld, tmr_done, dsk_q, take;
  logic [CW-1:0]     tmr_val;
  logic [BYTE_W-1:0] prev_q;

  assign take = (st_q == ST_PAYLOAD) && pl_valid;

  dwell_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ST_IDLE:   if (burst_req) begin st_d = ST_STOP; tmr_ld = 1'b1; tmr_val = STOP_DWELL; end
      ST_STOP:   if (tmr_done) begin st_d = ST_LP01; tmr_ld = 1'b1; tmr_val = cnt_lp01; end
      ST_LP01:   if (tmr_done) begin st_d = ST_LP00; tmr_ld = 1'b1; tmr_val = cnt_lp00; end
      ST_LP00:   if (tmr_done) begin st_d = ST_ZERO; tmr_ld = 1'b1; tmr_val = cnt_hszero; end
      ST_ZERO:
        if (tmr_done) begin
          if (dsk_q) begin st_d = ST_DESKEW; tmr_ld = 1'b1; tmr_val = cnt_deskew; end
          else st_d = ST_SYNC;
        end
      ST_DESKEW: if (tmr_done) st_d = ST_SYNC;
      ST_SYNC:   st_d = ST_PAYLOAD;
      ST_PAYLOAD: if (take && pl_last) begin st_d = ST_TRAIL; tmr_ld = 1'b1; tmr_val = cnt_trail; end
      ST_TRAIL:  if (tmr_done) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dsk_q  <= 1'b0;
      prev_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && burst_req) dsk_q <= deskew_en;
      if (st_q == ST_SYNC) prev_q <= SYNC_BYTE;
      else if (take) prev_q <= pl_data;
    end
  end

  hs_byte_sel u_sel (
    .st(st_q), .in_valid(pl_valid), .in_data(pl_data), .prev_byte(prev_q), .out_byte(hs_byte)
  );

  assign busy     = (st_q != ST_IDLE);
  assign pl_ready = (st_q == ST_PAYLOAD);
  assign lp_pos   = (st_q == ST_IDLE) || (st_q == ST_STOP);
  assign lp_neg   = (st_q == ST_IDLE) || (st_q == ST_STOP) || (st_q == ST_LP01);
  assign hs_en    = (st_q == ST_ZERO) || (st_q == ST_DESKEW) || (st_q == ST_SYNC) ||
                    (st_q == ST_PAYLOAD) || (st_q == ST_TRAIL);

  // R3
  ladder_leave_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_pos) |-> lp_neg);
  // R4
  hs_from_lp00_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(!lp_pos && !lp_neg) && hs_byte == '0));
  // R6
  sync_before_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pl_ready) |-> ($past(hs_byte) == SYNC_BYTE && $past(hs_en)));
  // R7
  ready_only_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (hs_en && busy && !lp_pos && !lp_neg));
  // R9
  idle_on_stop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (lp_pos && lp_neg && !hs_en));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(lp_pos && lp_neg)) |=> !(lp_pos && lp_neg && busy));
endmodule

// File: tb/sim_lane_burst_seq.sv
module sim_lane_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int LP11 = 8;

  logic clk = 1'b0, rst_n = 1'b0, burst_req = 1'b0, deskew_en = 1'b0;
  logic [CW-1:0] cnt_lp01 = '0, cnt_lp00 = '0, cnt_hszero = '0, cnt_deskew = '0, cnt_trail = '0;
  logic pl_valid = 1'b0, pl_last = 1'b0, pl_ready, lp_pos, lp_neg, hs_en, busy;
  logic [7:0] pl_data = '0, hs_byte;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] pay [0:15];
  int gap [0:15];
  int npay = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_burst_seq #(.CW(CW), .LP11_CYC(LP11)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .deskew_en(deskew_en),
    .cnt_lp01(cnt_lp01), .cnt_lp00(cnt_lp00), .cnt_hszero(cnt_hszero),
    .cnt_deskew(cnt_deskew), .cnt_trail(cnt_trail), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_last(pl_last), .pl_ready(pl_ready), .lp_pos(lp_pos),
    .lp_neg(lp_neg), .hs_en(hs_en), .hs_byte(hs_byte), .busy(busy)
  );

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [12:0] outs();
    return {lp_pos, lp_neg, hs_en, busy, pl_ready, hs_byte};
  endfunction

  // Checks cyc consecutive cycles starting at the current falling edge.
  task automatic expect_seg(string req, int cyc, logic p, logic n, logic hs,
                            logic bsy, logic rdy, logic [7:0] b, logic rq);
    logic [12:0] exp_v, bad_v;
    bit bad = 1'b0;
    exp_v = {p, n, hs, bsy, rdy, b};
    bad_v = '0;
    burst_req = rq;
    for (int i = 0; i < cyc; i++) begin
      #1;
      if (outs() !== exp_v && !bad) begin bad = 1'b1; bad_v = outs(); end
      @(negedge clk);
    end
    burst_req = 1'b0;
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: {p,n,hs,busy,rdy,byte} actual %h expected %h", req, bad_v, exp_v);
    end
  endtask

  task automatic check_now(string req, logic [7:0] act, logic [7:0] exp_b);
    checks++;
    if (act !== exp_b) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_b);
    end
  endtask

  task automatic run_burst(int n01, int n00, int nz, int nd, bit dsk, int ntr, bit req_in_zero);
    logic [7:0] prev;
    @(negedge clk);
    cnt_lp01 = CW'(n01); cnt_lp00 = CW'(n00); cnt_hszero = CW'(nz);
    cnt_deskew = CW'(nd); cnt_trail = CW'(ntr);
    deskew_en = dsk; burst_req = 1'b1;
    @(negedge clk);
    burst_req = 1'b0;
    deskew_en = ~dsk; // R5: must not matter once the request is taken
    expect_seg("R2 stop dwell", LP11, 1, 1, 0, 1, 0, 8'h00, 0);
    expect_seg("R3 lp01", eff(n01), 0, 1, 0, 1, 0, 8'h00, 0);
    expect_seg("R3 lp00", eff(n00), 0, 0, 0, 1, 0, 8'h00, 0);
    expect_seg("R4 zeros (R10 req held)", eff(nz), 0, 0, 1, 1, 0, 8'h00, req_in_zero);
    if (dsk) expect_seg("R5 deskew run", eff(nd), 0, 0, 1, 1, 0, 8'hBC, 0);
    expect_seg("R6 sync", 1, 0, 0, 1, 1, 0, 8'hB8, 0);
    prev = 8'hB8;
    for (int i = 0; i < npay; i++) begin
      for (int g = 0; g < gap[i]; g++) begin
        pl_valid = 1'b0;
        #1;
        check_now("R7 stall repeats previous byte", hs_byte, prev);
        check_now("R7 ready in stall", {7'd0, pl_ready}, 8'd1);
        @(negedge clk);
      end
      pl_valid = 1'b1; pl_data = pay[i]; pl_last = (i == npay - 1);
      #1;
      check_now("R7 passthrough", hs_byte, pay[i]);
      check_now("R7 ready high", {7'd0, pl_ready}, 8'd1);
      prev = pay[i];
      @(negedge clk);
      pl_valid = 1'b0; pl_last = 1'b0;
    end
    expect_seg("R8 trail", eff(ntr), 0, 0, 1, 1, 0, {8{~prev[7]}}, 0);
    expect_seg("R9 back to idle", 4, 1, 1, 0, 0, 0, 8'h00, 0);
    deskew_en = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    checks++;
    if ({lp_pos, lp_neg, hs_en, busy, pl_ready} !== 5'b11000) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected 11000", {lp_pos, lp_neg, hs_en, busy, pl_ready});
    end
    expect_seg("R1 idle with no request", 3, 1, 1, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic t_plain();
    npay = 3; pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h35;
    gap[0] = 0; gap[1] = 0; gap[2] = 0;
    run_burst(2, 3, 4, 5, 0, 3, 0);
  endtask

  task automatic t_deskew_gaps();
    npay = 4; pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF; pay[3] = 8'h80;
    gap[0] = 2; gap[1] = 0; gap[2] = 3; gap[3] = 1;
    run_burst(1, 2, 3, 6, 1, 2, 0);
  endtask

  task automatic t_zero_counts();
    npay = 1; pay[0] = 8'h7E; gap[0] = 0;
    run_burst(0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_req_while_busy();
    npay = 2; pay[0] = 8'h3C; pay[1] = 8'hC3; gap[0] = 0; gap[1] = 1;
    run_burst(2, 2, 5, 2, 0, 4, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_deskew_gaps();
    t_zero_counts();
    t_req_while_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule